// File: doc/BRIEF.md
# Flash Hardware-Reset and Ready/Busy Sequencer

This block sits inside a parallel NOR-style flash device, beside the command state machine and the embedded program/erase engine. It watches the active-low hardware reset pin. A low pulse on that pin counts only once it has lasted a minimum number of clock cycles. When a pulse qualifies, the block sends a single-cycle abort to the algorithm engine and to the command decoder, which stops any running program or erase and returns the decoder to array-read mode. It also holds the data pins in high impedance and drops every bus command until recovery is over.

The recovery time depends on what was running when the reset qualified. If an embedded algorithm was busy, the internal reset takes the long interval. Ready/busy stays low for that whole interval. If nothing was running, the internal reset takes a shorter interval and ready/busy stays high. Reads and command writes are only allowed again after two conditions hold: the internal reset has finished, and a separate recovery delay has passed since the pin returned high. The synchronous system reset `rst` stands for power-up and leaves the block in the same open, array-read state.

All timing values are parameters counted in clock cycles. Bus strobes and `algo_busy` are treated as synchronous inputs. The reset pin goes through a configurable synchronizer before its width is measured.

Top module: `flash_rst_seq`

## Requirements
- R1: The reset pin passes through a SYNC_STAGES-flop synchronizer (default 2), reset value high. A pulse qualifies only when the pin is sampled low at T_RP consecutive rising edges. A shorter pulse produces no abort and leaves `rdy_o` unchanged.
- R2: `abort_o` is high for exactly one cycle per qualified pulse. Count the first edge at which the pin is sampled low as edge 1. `abort_o` is then high after edge T_RP+2.
- R3: `out_hiz` is 1 (data pins tri-stated) whenever `read_ok` is 0. This covers the whole time the pin is held low and the recovery after it.
- R4: While the synchronized pin is low, `cmd_wr_ok` and `read_ok` are 0 from the next edge on. This also applies to pulses too short to qualify.
- R5: If `algo_busy` is 1 in the qualifying cycle, `rdy_o` goes to 0 on the same edge as `abort_o`. It returns to 1 exactly T_RDY_BUSY edges later, provided the pin is high again and `algo_busy` is 0.
- R6: If `algo_busy` is 0 in the qualifying cycle, `rdy_o` stays 1 throughout. Reads stay blocked for T_RDY_IDLE edges after the edge that raises `abort_o`.
- R7: Let r be the first edge at which the pin is sampled high after a qualified pulse. `read_ok` returns to 1 after edge r+T_RH+2 or after the internal reset ends, whichever is later.
- R8: After `rst`: `abort_o`=0, `rdy_o`=1, `read_ok`=1, `out_hiz`=1, `cmd_wr_ok`=0.
- R9: All outputs are registered one cycle after their inputs. `out_hiz` is 0 only for a read (ce_n=0, oe_n=0, we_n=1) while reads are open. `cmd_wr_ok` is 1 only for a write (ce_n=0, we_n=0, oe_n=1) while reads are open.
- R10: Outside any reset or recovery interval, `rdy_o` follows the inverse of `algo_busy` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| algo_busy | input | 1 | Embedded program/erase running |
| abort_o | output | 1 | One-cycle abort to engine and command decoder |
| out_hiz | output | 1 | 1 = data pins high impedance |
| rdy_o | output | 1 | Ready/busy, 0 = busy |
| read_ok | output | 1 | Reads and commands permitted |
| cmd_wr_ok | output | 1 | Qualified command write strobe |

## Verification
The bench aims at pulses one cycle short of the qualifying width and pulses exactly at it. If the threshold is off by one, a glitch aborts an operation, or a valid reset is missed. It also resets once with an algorithm running and once with none. A design that mixes up the two intervals either pulls ready/busy low on an idle reset or releases it early, and the bench measures that edge count exactly. Random pulse lengths, busy toggles and bus strobes are compared every cycle against an independent model. This exposes reads that reopen before the post-release delay or before the internal reset finishes, and commands that leak through while the pin is low.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;

  function automatic int cnt_w(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/frs_pulse_qual.sv
module frs_pulse_qual #(
  parameter int T_RP = 8,
  localparam int CW = flash_rst_pkg::cnt_w(T_RP)
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic qual,
  output logic held
);
  logic [CW-1:0] low_cnt;

  assign qual = !lvl && !held && (low_cnt == CW'(T_RP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      held    <= 1'b0;
    end else if (lvl) begin
      low_cnt <= '0;
      held    <= 1'b0;
    end else if (!held) begin
      low_cnt <= low_cnt + 1'b1;
      if (qual) held <= 1'b1;
    end
  end
endmodule

// File: rtl/frs_countdown.sv
module frs_countdown #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle_nxt
);
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    if (load)            cnt_nxt = load_val;
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
    else                 cnt_nxt = '0;
  end

  assign idle_nxt = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/frs_bus_decode.sv
module frs_bus_decode
  import flash_rst_pkg::*;
(
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  output bus_op_e op
);
  always_comb begin
    op = BUS_IDLE;
    if (!ce_n) begin
      if (!oe_n && we_n)      op = BUS_READ;
      else if (oe_n && !we_n) op = BUS_WRITE;
    end
  end
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int T_RP        = 8,
  parameter int T_RDY_BUSY  = 40,
  parameter int T_RDY_IDLE  = 12,
  parameter int T_RH        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic algo_busy,
  output logic abort_o,
  output logic out_hiz,
  output logic rdy_o,
  output logic read_ok,
  output logic cmd_wr_ok
);
  localparam int IW = cnt_w(max2(T_RDY_BUSY, T_RDY_IDLE));
  localparam int HW = cnt_w(T_RH);

  logic    pin_s;
  logic    qual;
  logic    held;
  logic    int_idle_nxt;
  logic    rh_idle_nxt;
  logic    busy_rst;
  logic    busy_rst_nxt;
  logic    in_rst;
  logic    open_nxt;
  bus_op_e op;

  frs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rst_pin_n), .q(pin_s)
  );

  frs_pulse_qual #(.T_RP(T_RP)) u_qual (
    .clk(clk), .rst(rst), .lvl(pin_s), .qual(qual), .held(held)
  );

  frs_countdown #(.W(IW)) u_int_tmr (
    .clk(clk), .rst(rst), .load(qual),
    .load_val(algo_busy ? IW'(T_RDY_BUSY) : IW'(T_RDY_IDLE)),
    .idle_nxt(int_idle_nxt)
  );

  frs_countdown #(.W(HW)) u_rh_tmr (
    .clk(clk), .rst(rst), .load(pin_s && held),
    .load_val(HW'(T_RH)),
    .idle_nxt(rh_idle_nxt)
  );

  frs_bus_decode u_dec (.ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .op(op));

  assign busy_rst_nxt = qual ? algo_busy : (busy_rst && !int_idle_nxt);
  assign in_rst       = qual || held || !int_idle_nxt;
  assign open_nxt     = pin_s && rh_idle_nxt && int_idle_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_o   <= 1'b0;
      busy_rst  <= 1'b0;
      rdy_o     <= 1'b1;
      read_ok   <= 1'b1;
      out_hiz   <= 1'b1;
      cmd_wr_ok <= 1'b0;
    end else begin
      abort_o   <= qual;
      busy_rst  <= busy_rst_nxt;
      rdy_o     <= in_rst ? !busy_rst_nxt : !algo_busy;
      read_ok   <= open_nxt;
      out_hiz   <= !(open_nxt && (op == BUS_READ));
      cmd_wr_ok <= open_nxt && (op == BUS_WRITE);
    end
  end
endmodule

// File: rtl/frs_checker.sv
module frs_checker (
  input logic clk,
  input logic rst,
  input logic pin_s,
  input logic held,
  input logic algo_busy,
  input logic abort_o,
  input logic out_hiz,
  input logic rdy_o,
  input logic read_ok,
  input logic cmd_wr_ok
);
  AST_ABORT_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !$past(pin_s)); // R1
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o); // R2
  AST_HIZ_UNLESS_OPEN: assert property (@(posedge clk) disable iff (rst)
    !read_ok |-> out_hiz); // R3
  AST_PIN_LOW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !pin_s |=> (!cmd_wr_ok && !read_ok)); // R4
  AST_BUSY_PATH: assert property (@(posedge clk) disable iff (rst)
    (abort_o && $past(algo_busy)) |-> !rdy_o); // R5
  AST_IDLE_PATH: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !$past(algo_busy)) |-> rdy_o); // R6
  AST_RISE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (pin_s && held) |=> !read_ok); // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    cmd_wr_ok |-> out_hiz); // R9
endmodule

bind flash_rst_seq frs_checker u_chk (
  .clk(clk), .rst(rst), .pin_s(pin_s), .held(held), .algo_busy(algo_busy),
  .abort_o(abort_o), .out_hiz(out_hiz), .rdy_o(rdy_o), .read_ok(read_ok),
  .cmd_wr_ok(cmd_wr_ok)
);

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb;
  localparam int T_RP = 8;
  localparam int TB   = 40;
  localparam int TI   = 12;
  localparam int TH   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, algo_busy = 1'b0;
  logic abort_o, out_hiz, rdy_o, read_ok, cmd_wr_ok;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_rst_seq #(.T_RP(T_RP), .T_RDY_BUSY(TB), .T_RDY_IDLE(TI), .T_RH(TH)) u_dut (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .algo_busy(algo_busy), .abort_o(abort_o), .out_hiz(out_hiz),
    .rdy_o(rdy_o), .read_ok(read_ok), .cmd_wr_ok(cmd_wr_ok)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Reference model: counts ages of pin levels, kept apart from the design.
  bit p1 = 1, p2 = 1, e_abort = 0, e_hiz = 1, e_rdy = 1, e_rd = 1, e_wr = 0, bz = 0;
  int low_age = 0, rem = 0, rh = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      p1 <= 1; p2 <= 1; low_age <= 0; rem <= 0; rh <= 0; bz <= 0;
      e_abort <= 0; e_hiz <= 1; e_rdy <= 1; e_rd <= 1; e_wr <= 0;
    end else begin
      bit q, rise, bz_n, inr, open;
      int rem_n, rh_n;
      q     = !p2 && (low_age == T_RP - 1);
      rise  = p2 && (low_age == T_RP);
      rem_n = q ? (algo_busy ? TB : TI) : ((rem > 0) ? rem - 1 : 0);
      rh_n  = rise ? TH : ((rh > 0) ? rh - 1 : 0);
      bz_n  = q ? algo_busy : (bz && rem_n > 0);
      inr   = q || (low_age == T_RP) || (rem_n > 0);
      open  = p2 && rh_n == 0 && rem_n == 0;
      e_abort <= q;
      e_rdy   <= inr ? !bz_n : !algo_busy;
      e_rd    <= open;
      e_wr    <= open && !ce_n && !we_n && oe_n;
      e_hiz   <= !(open && !ce_n && !oe_n && we_n);
      low_age <= p2 ? 0 : ((low_age < T_RP) ? low_age + 1 : low_age);
      rem <= rem_n; rh <= rh_n; bz <= bz_n;
      p1 <= rst_pin_n; p2 <= p1;
    end
  end

  // Per-cycle comparison and event capture, away from the active edge.
  int abort_cnt = 0, abort_cyc = 0, rdy_rise_cyc = 0, rd_rise_cyc = 0;
  bit rdy_low_seen = 0, prev_rdy = 1, prev_rd = 1;

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", "abort_o", abort_o, e_abort);
      chk("R3", "out_hiz", out_hiz, e_hiz);
      chk("R10", "rdy_o", rdy_o, e_rdy);
      chk("R7", "read_ok", read_ok, e_rd);
      chk("R4", "cmd_wr_ok", cmd_wr_ok, e_wr);
      if (abort_o) begin abort_cnt++; abort_cyc = cyc; end
      if (!rdy_o) rdy_low_seen = 1;
      if (rdy_o && !prev_rdy) rdy_rise_cyc = cyc;
      if (read_ok && !prev_rd) rd_rise_cyc = cyc;
      prev_rdy = rdy_o;
      prev_rd  = read_ok;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_events();
    abort_cnt = 0; rdy_low_seen = 0; abort_cyc = 0; rdy_rise_cyc = 0; rd_rise_cyc = 0;
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d, r_d, exp_rd;
    void'($urandom(32'h1f2e3d4c));
    wait_cyc(4);
    // R8: reset state
    chk("R8", "abort_o", abort_o, 0);
    chk("R8", "rdy_o", rdy_o, 1);
    chk("R8", "read_ok", read_ok, 1);
    chk("R8", "out_hiz", out_hiz, 1);
    chk("R8", "cmd_wr_ok", cmd_wr_ok, 0);
    rst = 1'b0;
    wait_cyc(5);

    // R1: one cycle short of qualifying
    clear_events();
    algo_busy = 1'b0;
    rst_pin_n = 1'b0; wait_cyc(T_RP - 1); rst_pin_n = 1'b1;
    wait_cyc(20);
    chk("R1", "short pulse aborts", abort_cnt, 0);
    chk("R1", "short pulse rdy low", rdy_low_seen, 0);

    // R2/R5/R7: reset during an embedded algorithm
    algo_busy = 1'b1; wait_cyc(3);
    clear_events();
    d = cyc;
    rst_pin_n = 1'b0; wait_cyc(T_RP + 5);
    algo_busy = 1'b0;
    r_d = cyc;
    rst_pin_n = 1'b1;
    wait_cyc(TB + TH + 10);
    chk("R2", "abort count", abort_cnt, 1);
    chk("R2", "abort latency", abort_cyc - d, T_RP + 2);
    chk("R5", "busy interval", rdy_rise_cyc - abort_cyc, TB);
    exp_rd = (r_d + 3 + TH > abort_cyc + TB) ? r_d + 3 + TH : abort_cyc + TB;
    chk("R7", "read reopen busy path", rd_rise_cyc, exp_rd);

    // R6/R7: reset with nothing running
    clear_events();
    d = cyc;
    rst_pin_n = 1'b0; wait_cyc(T_RP + 2);
    r_d = cyc;
    rst_pin_n = 1'b1;
    wait_cyc(TI + TH + 10);
    chk("R6", "abort count idle", abort_cnt, 1);
    chk("R6", "rdy stays high", rdy_low_seen, 0);
    exp_rd = (r_d + 3 + TH > abort_cyc + TI) ? r_d + 3 + TH : abort_cyc + TI;
    chk("R7", "read reopen idle path", rd_rise_cyc, exp_rd);

    // R9: bus decode in the open state
    ce_n = 0; oe_n = 0; we_n = 1; wait_cyc(2);
    chk("R9", "read drives pins", out_hiz, 0);
    ce_n = 0; oe_n = 1; we_n = 0; wait_cyc(2);
    chk("R9", "write strobe", cmd_wr_ok, 1);
    ce_n = 1; we_n = 1; wait_cyc(2);

    // Random phase, compared against the model each cycle
    begin
      int pulse_left = 0;
      for (int i = 0; i < 6000; i++) begin
        if (pulse_left > 0) begin
          rst_pin_n = 1'b0; pulse_left--;
        end else begin
          rst_pin_n = 1'b1;
          if ($urandom_range(0, 59) == 0) begin
            case ($urandom_range(0, 3))
              0: pulse_left = T_RP - 1;
              1: pulse_left = T_RP;
              default: pulse_left = $urandom_range(1, 3 * T_RP);
            endcase
          end
        end
        if ($urandom_range(0, 19) == 0) algo_busy = ~algo_busy;
        ce_n = 1'($urandom_range(0, 1));
        oe_n = 1'($urandom_range(0, 1));
        we_n = 1'($urandom_range(0, 1));
        wait_cyc(1);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule